// File: doc/BRIEF.md
# UART DMA Channel Control Sequencer

This block is the control front end of one UART DMA channel. Software reaches it over a simple word-addressed register bus. A write takes effect at the clock edge on which the write strobe is high. The read data is a combinational view of the register selected by the current address. The block holds the channel enable, the stop request, the drain (flush) request, the interrupt enables and the interrupt flags. It also decodes a warm-reset command and an upper-address-bit extension flag.

Toward the data engine it drives a run level, a drain request, a one-cycle warm-reset pulse and the address extension bit. From the engine it takes an idle indication, a drain-complete pulse, receive event pulses and a transmit level that says the free space has reached the threshold. From these it runs two handshakes. In the stop handshake, software raises stop and the hardware drops enable itself. In the drain handshake, the flush bit clears itself once the engine reports completion.

The pointer arithmetic and the memory bus master are separate sibling blocks.

Top module: `dma_chan_ctl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. The run, drain request, interrupt, warm-reset pulse and address extension outputs are all 0.
- R2: Writing 1 to bit 0 of the enable register (word 2) makes that register read exactly 1 and raises `run`. `run` is enable AND NOT stop.
- R3: Writing 1 to the stop register (word 4) drops `run` at once. Enable then clears on the first edge at which stop is 1 and `eng_idle` is high. Writing 0 to stop ends the handshake.
- R4: While stop is 1, a write of 1 to the enable register leaves enable at 0.
- R5: With the engine never idle, enable clears exactly STOP_LIMIT cycles after the edge that set stop. It still reads 1 one cycle earlier.
- R6: Writing 1 to the flush register (word 5) sets it and raises `drain_req`. Writing 0 has no effect. The bit clears on the edge where `drain_done` is high.
- R7: Writing 1 to the warm-reset register (word 3) clears enable, stop, flush, the interrupt enables, the flags and the address extension at that edge. It raises `warm_rst` for exactly one cycle. Word 3 reads 0.
- R8: Bit 0 of the address extension register (word 21) is stored and drives `addr_ext`.
- R9: In receive mode (`dir_rx`=1), a pulse on `rx_event[i]` sets flag bit i of the flag register (word 0). Writing a 1 in bit i clears that bit, writing 0 leaves it, and a set wins over a clear in the same cycle.
- R10: `irq` is the OR over all bits of flag AND interrupt enable (word 1, bits 1:0).
- R11: In transmit mode, `tx_above` with interrupt enable bit 0 set raises flag bit 0 on the next edge. On the edge after that, hardware clears interrupt enable bit 0, so `irq` is high for one cycle.
- R12: In transmit mode, a flag-register write with bit 0 equal to 0 clears flag bit 0, and a write with bit 0 equal to 1 leaves it set.
- R13: The debug word (word 20) shows enable in bit 0, stop in bit 1, flush in bit 2 and engine idle in bit 3. Bits 5:4 hold the flags, bits 7:6 the interrupt enables, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| dir_rx | input | 1 | 1 = receive mode, 0 = transmit mode |
| eng_idle | input | 1 | Data engine is idle |
| drain_done | input | 1 | Engine finished draining pending data |
| rx_event | input | NFLAG | Receive interrupt event pulses |
| tx_above | input | 1 | Transmit free space at or above threshold |
| run | output | 1 | Engine may move data |
| drain_req | output | 1 | Drain request to the engine |
| warm_rst | output | 1 | One-cycle warm reset pulse to the engine |
| addr_ext | output | 1 | Upper base-address bit enable |
| irq | output | 1 | Channel interrupt |

## Verification
A register write becomes visible on the read port, and on `run`, `drain_req` and `addr_ext`, one clock after its write edge. `warm_rst` is high in that same cycle only. Engine-side conditions act one edge later: idle-driven enable clear, drain completion and flag set. The hardware drop of the transmit interrupt enable comes a second edge after the flag rises, and the stop time limit lands exactly STOP_LIMIT edges after stop is set. The bench drives inputs at the falling edge and queues each expectation at the falling edge where the result is due. It compares one time unit later, and reads at most one register per cycle because read data follows the address.

// File: rtl/dmactl_pkg.sv
// Package: shared register indices and the write-strobe bundle of the
// channel control sequencer. Assumes a word-addressed bus.
package dmactl_pkg;

    // Word indices of the control registers (byte offset / 4)
    localparam int IDX_FLAG  = 0;
    localparam int IDX_IEN   = 1;
    localparam int IDX_EN    = 2;
    localparam int IDX_WRST  = 3;
    localparam int IDX_STOP  = 4;
    localparam int IDX_FLUSH = 5;
    localparam int IDX_DBG   = 20;
    localparam int IDX_EXT   = 21;

    // One write strobe per writable register
    typedef struct packed {
        logic flag;
        logic ien;
        logic en;
        logic wrst;
        logic stop;
        logic flush;
        logic ext;
    } wr_stb_t;

endpackage

// File: rtl/dmactl_regdec.sv
// Module: decodes a bus write into one strobe per register.
// Assumes the address is a word index; unknown indices produce no strobe.
module dmactl_regdec
    import dmactl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_stb_t           stb
);

    // Purpose: raise the strobe of the addressed register during a write
    always_comb begin
        stb = '0;
        if (bus_wr) begin
            stb.flag  = (bus_addr == ADDR_W'(IDX_FLAG));
            stb.ien   = (bus_addr == ADDR_W'(IDX_IEN));
            stb.en    = (bus_addr == ADDR_W'(IDX_EN));
            stb.wrst  = (bus_addr == ADDR_W'(IDX_WRST));
            stb.stop  = (bus_addr == ADDR_W'(IDX_STOP));
            stb.flush = (bus_addr == ADDR_W'(IDX_FLUSH));
            stb.ext   = (bus_addr == ADDR_W'(IDX_EXT));
        end
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb)); // R2

endmodule

// File: rtl/dmactl_run_ctrl.sv
// Module: enable / stop / flush / warm-reset sequencing and the address
// extension bit. Assumes the engine pulses drain_done and holds eng_idle
// as a level. Enable is dropped by hardware when stop is set and the engine
// is idle, or after STOP_LIMIT cycles at most.
module dmactl_run_ctrl #(
    parameter int STOP_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_en,
    input  logic stb_stop,
    input  logic stb_flush,
    input  logic stb_ext,
    input  logic warm_req,
    input  logic wbit,
    input  logic eng_idle,
    input  logic drain_done,
    output logic en,
    output logic stop,
    output logic flush,
    output logic ext,
    output logic warm_pulse
);

    localparam int CNT_W = $clog2(STOP_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STOP_LIMIT - 1);

    logic [CNT_W-1:0] stop_cnt;
    logic             force_off;

    // Purpose: enable must fall because stop is pending and engine is quiet or time is up
    assign force_off = stop && (eng_idle || (stop_cnt == CNT_LAST));

    // Purpose: register state update with warm reset taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            stop       <= 1'b0;
            flush      <= 1'b0;
            ext        <= 1'b0;
            warm_pulse <= 1'b0;
            stop_cnt   <= '0;
        end else if (warm_req) begin
            en         <= 1'b0;
            stop       <= 1'b0;
            flush      <= 1'b0;
            ext        <= 1'b0;
            warm_pulse <= 1'b1;
            stop_cnt   <= '0;
        end else begin
            warm_pulse <= 1'b0;
            if (stb_stop) begin
                stop <= wbit;
            end
            if (force_off) begin
                en <= 1'b0;
            end else if (stb_en) begin
                en <= wbit && !stop;
            end
            if (!stop || !en) begin
                stop_cnt <= '0;
            end else if (stop_cnt != CNT_LAST) begin
                stop_cnt <= stop_cnt + 1'b1;
            end
            if (flush && drain_done) begin
                flush <= 1'b0;
            end else if (stb_flush && wbit) begin
                flush <= 1'b1;
            end
            if (stb_ext) begin
                ext <= wbit;
            end
        end
    end

    AST_STOP_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && eng_idle) |=> !en); // R3

    AST_EN_HELD_BY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !en) |=> !en); // R4

    AST_FLUSH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush) |-> ($past(drain_done) || $past(warm_req))); // R6

    AST_WARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        warm_req |=> (!en && !stop && !flush && !ext && warm_pulse)); // R7

    AST_WARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_pulse && !warm_req) |=> !warm_pulse); // R7

endmodule

// File: rtl/dmactl_irq_ctrl.sv
// Module: interrupt flags, interrupt enables and the combined interrupt.
// Receive mode: event pulses set flags, written ones clear them.
// Transmit mode: flag 0 follows the threshold level while enabled, a written
// zero clears it, and hardware drops enable 0 after the flag is seen.
module dmactl_irq_ctrl #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_req,
    input  logic             dir_rx,
    input  logic             stb_flag,
    input  logic             stb_ien,
    input  logic [NFLAG-1:0] wdata,
    input  logic [NFLAG-1:0] rx_event,
    input  logic             tx_above,
    output logic [NFLAG-1:0] flag,
    output logic [NFLAG-1:0] ien,
    output logic             irq
);

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic             tx_ien_drop;

    // Purpose: per-bit set and clear terms; bit 0 also serves transmit mode
    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        if (gi == 0) begin : g_txbit
            assign set_v[gi] = dir_rx ? rx_event[gi] : (tx_above && ien[gi]);
            assign clr_v[gi] = stb_flag && (dir_rx ? wdata[gi] : !wdata[gi]);
        end else begin : g_rxbit
            assign set_v[gi] = dir_rx && rx_event[gi];
            assign clr_v[gi] = dir_rx && stb_flag && wdata[gi];
        end
    end

    // Purpose: transmit enable auto-clear once the flag has been raised
    assign tx_ien_drop = !dir_rx && tx_above && ien[0] && flag[0];

    // Purpose: flag and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n || warm_req) begin
            flag <= '0;
            ien  <= '0;
        end else begin
            flag <= (flag & ~clr_v) | set_v;
            if (stb_ien) begin
                ien <= wdata;
            end else if (tx_ien_drop) begin
                ien[0] <= 1'b0;
            end
        end
    end

    // Purpose: combined interrupt level
    assign irq = |(flag & ien);

    AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rx && rx_event[0] && !warm_req) |=> flag[0]); // R9

    AST_TX_IEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rx && tx_above && ien[0] && flag[0] && !stb_ien) |=> !ien[0]); // R11

    AST_TX_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rx && stb_flag && !wdata[0] && !(tx_above && ien[0])) |=> !flag[0]); // R12

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq); // R10

endmodule

// File: rtl/dma_chan_ctl.sv
// Module: top of the channel control sequencer. Decodes register writes,
// runs the enable/stop/flush handshakes and the interrupt logic, and
// multiplexes a combinational read view. Assumes NFLAG <= 2 so the debug
// word layout fits its documented fields.
module dma_chan_ctl
    import dmactl_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int NFLAG      = 2,
    parameter int STOP_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dir_rx,
    input  logic              eng_idle,
    input  logic              drain_done,
    input  logic [NFLAG-1:0]  rx_event,
    input  logic              tx_above,
    output logic              run,
    output logic              drain_req,
    output logic              warm_rst,
    output logic              addr_ext,
    output logic              irq
);

    localparam int DBG_FLAG_LSB = 4;
    localparam int DBG_IEN_LSB  = DBG_FLAG_LSB + NFLAG;

    wr_stb_t          stb;
    logic             warm_req;
    logic             en;
    logic             stop;
    logic             flush;
    logic             ext;
    logic [NFLAG-1:0] flag;
    logic [NFLAG-1:0] ien;
    logic [DATA_W-1:0] dbg;
    logic             unused_wdata;

    // Purpose: upper write-data bits carry no register content
    assign unused_wdata = ^bus_wdata[DATA_W-1:NFLAG];

    dmactl_regdec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .stb      (stb)
    );

    // Purpose: warm reset command fires on a write of 1
    assign warm_req = stb.wrst && bus_wdata[0];

    dmactl_run_ctrl #(
        .STOP_LIMIT (STOP_LIMIT)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_en     (stb.en),
        .stb_stop   (stb.stop),
        .stb_flush  (stb.flush),
        .stb_ext    (stb.ext),
        .warm_req   (warm_req),
        .wbit       (bus_wdata[0]),
        .eng_idle   (eng_idle),
        .drain_done (drain_done),
        .en         (en),
        .stop       (stop),
        .flush      (flush),
        .ext        (ext),
        .warm_pulse (warm_rst)
    );

    dmactl_irq_ctrl #(
        .NFLAG (NFLAG)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_req (warm_req),
        .dir_rx   (dir_rx),
        .stb_flag (stb.flag),
        .stb_ien  (stb.ien),
        .wdata    (bus_wdata[NFLAG-1:0]),
        .rx_event (rx_event),
        .tx_above (tx_above),
        .flag     (flag),
        .ien      (ien),
        .irq      (irq)
    );

    // Purpose: engine-facing levels
    assign run       = en && !stop;
    assign drain_req = flush;
    assign addr_ext  = ext;

    // Purpose: debug status word assembly
    always_comb begin
        dbg = '0;
        dbg[0] = en;
        dbg[1] = stop;
        dbg[2] = flush;
        dbg[3] = eng_idle;
        dbg[DBG_FLAG_LSB +: NFLAG] = flag;
        dbg[DBG_IEN_LSB +: NFLAG]  = ien;
    end

    // Purpose: combinational read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(IDX_FLAG)) begin
            bus_rdata[NFLAG-1:0] = flag;
        end else if (bus_addr == ADDR_W'(IDX_IEN)) begin
            bus_rdata[NFLAG-1:0] = ien;
        end else if (bus_addr == ADDR_W'(IDX_EN)) begin
            bus_rdata[0] = en;
        end else if (bus_addr == ADDR_W'(IDX_STOP)) begin
            bus_rdata[0] = stop;
        end else if (bus_addr == ADDR_W'(IDX_FLUSH)) begin
            bus_rdata[0] = flush;
        end else if (bus_addr == ADDR_W'(IDX_DBG)) begin
            bus_rdata = dbg;
        end else if (bus_addr == ADDR_W'(IDX_EXT)) begin
            bus_rdata[0] = ext;
        end
    end

    AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> ($past(stb.en) || $past(stb.stop))); // R2

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !drain_done && !warm_req) |=> drain_req); // R6

endmodule

// File: tb/sim_dma_chan_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctl;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam int NF = 2;
    localparam int LIM = 16;

    localparam logic [AW-1:0] A_FLAG  = 5'd0;
    localparam logic [AW-1:0] A_IEN   = 5'd1;
    localparam logic [AW-1:0] A_EN    = 5'd2;
    localparam logic [AW-1:0] A_WRST  = 5'd3;
    localparam logic [AW-1:0] A_STOP  = 5'd4;
    localparam logic [AW-1:0] A_FLUSH = 5'd5;
    localparam logic [AW-1:0] A_DBG   = 5'd20;
    localparam logic [AW-1:0] A_EXT   = 5'd21;

    // monitored item kinds
    localparam int K_RD = 0, K_RUN = 1, K_DRN = 2, K_IRQ = 3, K_WRST = 4, K_EXT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          dir_rx = 1'b0;
    logic          eng_idle = 1'b0;
    logic          drain_done = 1'b0;
    logic [NF-1:0] rx_event = '0;
    logic          tx_above = 1'b0;
    logic          run, drain_req, warm_rst, addr_ext, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int            q_kind[$];
    logic [DW-1:0] q_exp[$];
    string         q_tag[$];

    always #2.5 clk = ~clk;

    dma_chan_ctl #(
        .ADDR_W (AW), .DATA_W (DW), .NFLAG (NF), .STOP_LIMIT (LIM)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .dir_rx (dir_rx),
        .eng_idle (eng_idle), .drain_done (drain_done), .rx_event (rx_event),
        .tx_above (tx_above), .run (run), .drain_req (drain_req),
        .warm_rst (warm_rst), .addr_ext (addr_ext), .irq (irq)
    );

    // driver side: queue an expectation for this cycle
    task automatic expect_port(input int kind, input logic [DW-1:0] v, input string tag);
        q_kind.push_back(kind);
        q_exp.push_back(v);
        q_tag.push_back(tag);
    endtask

    task automatic expect_reg(input logic [AW-1:0] a, input logic [DW-1:0] v, input string tag);
        bus_addr = a;
        expect_port(K_RD, v, tag);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic pulse_rx(input logic [NF-1:0] v);
        rx_event = v;
        @(negedge clk);
        rx_event = '0;
    endtask

    // monitor: compare queued expectations just after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_kind.size() > 0) begin
                int k;
                logic [DW-1:0] e;
                logic [DW-1:0] act;
                string t;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                case (k)
                    K_RD:    act = bus_rdata;
                    K_RUN:   act = DW'(run);
                    K_DRN:   act = DW'(drain_req);
                    K_IRQ:   act = DW'(irq);
                    K_WRST:  act = DW'(warm_rst);
                    default: act = DW'(addr_ext);
                endcase
                n_cmp++;
                if (act !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(5 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        // R1 reset state
        expect_reg(A_EN, 0, "R1 enable");
        expect_port(K_RUN, 0, "R1 run");
        expect_port(K_DRN, 0, "R1 drain_req");
        expect_port(K_IRQ, 0, "R1 irq");
        expect_port(K_WRST, 0, "R1 warm_rst");
        expect_port(K_EXT, 0, "R1 addr_ext");
        step(1);
        expect_reg(A_FLAG, 0, "R1 flags");
        step(1);
        expect_reg(A_DBG, 0, "R1 debug");

        // R2 enable
        wr(A_EN, 1);
        expect_reg(A_EN, 32'h1, "R2 enable reads 1");
        expect_port(K_RUN, 1, "R2 run");

        // R3 stop handshake with idle engine
        wr(A_STOP, 1);
        expect_reg(A_EN, 1, "R3 enable before idle");
        expect_port(K_RUN, 0, "R3 run drops with stop");
        eng_idle = 1'b1;
        step(1);
        expect_reg(A_EN, 0, "R3 enable cleared by hardware");
        // R4 enable write ignored while stopping
        wr(A_EN, 1);
        expect_reg(A_EN, 0, "R4 enable stays 0 under stop");
        expect_port(K_RUN, 0, "R4 run");
        wr(A_STOP, 0);
        expect_reg(A_STOP, 0, "R3 stop released");

        // R5 bounded stop with busy engine
        eng_idle = 1'b0;
        wr(A_EN, 1);
        wr(A_STOP, 1);
        step(LIM - 1);
        expect_reg(A_EN, 1, "R5 enable one cycle before limit");
        step(1);
        expect_reg(A_EN, 0, "R5 enable at limit");
        wr(A_STOP, 0);

        // R6 flush
        wr(A_FLUSH, 1);
        expect_reg(A_FLUSH, 1, "R6 flush set");
        expect_port(K_DRN, 1, "R6 drain_req");
        step(3);
        expect_reg(A_FLUSH, 1, "R6 flush held");
        wr(A_FLUSH, 0);
        expect_reg(A_FLUSH, 1, "R6 write 0 ignored");
        drain_done = 1'b1;
        step(1);
        drain_done = 1'b0;
        expect_reg(A_FLUSH, 0, "R6 flush self-clears");
        expect_port(K_DRN, 0, "R6 drain_req low");

        // R8 address extension, R7 warm reset
        wr(A_EXT, 1);
        expect_reg(A_EXT, 1, "R8 ext reg");
        expect_port(K_EXT, 1, "R8 addr_ext");
        wr(A_EN, 1);
        wr(A_IEN, 3);
        wr(A_FLUSH, 1);
        wr(A_WRST, 1);
        expect_reg(A_EN, 0, "R7 enable cleared");
        expect_port(K_WRST, 1, "R7 warm_rst pulse");
        step(1);
        expect_reg(A_FLUSH, 0, "R7 flush cleared");
        expect_port(K_WRST, 0, "R7 warm_rst one cycle");
        step(1);
        expect_reg(A_IEN, 0, "R7 int enable cleared");
        step(1);
        expect_reg(A_EXT, 0, "R7 ext cleared");
        expect_port(K_EXT, 0, "R7 addr_ext cleared");
        step(1);
        expect_reg(A_WRST, 0, "R7 reset register reads 0");

        // R9 receive flags
        dir_rx = 1'b1;
        wr(A_IEN, 3);
        pulse_rx(2'b01);
        expect_reg(A_FLAG, 1, "R9 flag0 set");
        expect_port(K_IRQ, 1, "R10 irq on flag0");
        pulse_rx(2'b10);
        expect_reg(A_FLAG, 3, "R9 flag1 set");
        wr(A_FLAG, 0);
        expect_reg(A_FLAG, 3, "R9 write 0 keeps flags");
        wr(A_FLAG, 1);
        expect_reg(A_FLAG, 2, "R9 clear bit0");
        expect_port(K_IRQ, 1, "R10 irq on flag1");
        wr(A_FLAG, 2);
        expect_reg(A_FLAG, 0, "R9 clear bit1");
        expect_port(K_IRQ, 0, "R10 irq low");

        // R10 masking
        wr(A_IEN, 2);
        pulse_rx(2'b01);
        expect_reg(A_FLAG, 1, "R10 flag0 set while masked");
        expect_port(K_IRQ, 0, "R10 masked irq");
        wr(A_IEN, 3);
        expect_port(K_IRQ, 1, "R10 unmasked irq");
        wr(A_FLAG, 1);
        expect_port(K_IRQ, 0, "R10 irq after clear");

        // R11 transmit threshold
        dir_rx = 1'b0;
        wr(A_IEN, 1);
        tx_above = 1'b1;
        step(1);
        expect_reg(A_FLAG, 1, "R11 tx flag set");
        expect_port(K_IRQ, 1, "R11 irq one cycle");
        step(1);
        expect_reg(A_IEN, 0, "R11 int enable auto-cleared");
        expect_port(K_IRQ, 0, "R11 irq drops");
        tx_above = 1'b0;

        // R12 transmit clear by writing zero
        wr(A_FLAG, 1);
        expect_reg(A_FLAG, 1, "R12 write 1 keeps tx flag");
        wr(A_FLAG, 0);
        expect_reg(A_FLAG, 0, "R12 write 0 clears tx flag");

        // R13 debug word
        wr(A_WRST, 1);
        eng_idle = 1'b1;
        wr(A_EN, 1);
        wr(A_FLUSH, 1);
        dir_rx = 1'b1;
        wr(A_IEN, 2);
        pulse_rx(2'b01);
        expect_reg(A_DBG, 32'h9D, "R13 debug word");
        step(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule